// File: doc/BRIEF.md
# Credit-Gated Prefetch Byte Queue

This block is a small byte queue that fetches its own input from an upstream DMA engine and hands the bytes to a downstream consumer over a valid/ready stream. On the fetch side it raises a request, and the engine accepts that request with a grant. Some cycles later the engine returns the byte on a separate valid strobe. Between the grant and the return, the request counts as outstanding.

The queue keeps a count of outstanding requests and adds it to its current fill level. A new request goes out only while that sum is below the depth. A returned byte therefore always finds a free slot. Everything runs on one clock. A synchronous clear empties the storage and drops every outstanding credit. Use the clear only when the engine has also abandoned its in-flight returns.

The fill level is tracked by a three-state controller. The states are FS_EMPTY (no bytes held), FS_PART (some bytes held, below the depth) and FS_FULL (depth reached). The transitions are:
- FS_EMPTY to FS_PART on a push.
- FS_PART to FS_FULL on a push without a pop when one slot was free.
- FS_PART to FS_EMPTY on a pop without a push when one byte was held.
- FS_FULL to FS_PART on a pop.
- Any state to FS_EMPTY on clear.

When the depth is one, FS_EMPTY and FS_FULL connect directly.

Top module: `credit_prefetch_fifo`

## Requirements
- R1: After reset the queue is empty: valid_o is low, ready_o is high and req_o is high.
- R2: ready_o is high exactly when fewer than DEPTH (default 2) bytes are held.
- R3: req_o is high exactly when clr_i is low and held bytes plus outstanding requests are below DEPTH.
- R4: A cycle with req_o and gnt_i high adds one outstanding request. A cycle with valid_i and ready_o high removes one. A cycle with both leaves the count unchanged.
- R5: A byte on data_i is stored when valid_i and ready_o are high, and bytes leave in the order they were stored.
- R6: valid_o is high exactly when at least one byte is held, and data_o shows the oldest held byte.
- R7: While valid_o is high and ready_i is low, data_o and valid_o hold their values into the next cycle.
- R8: A cycle with both a push and a pop leaves the fill level, and hence ready_o and valid_o, unchanged.
- R9: clr_i high at a clock edge empties the queue and zeroes the outstanding count. req_o is low during that cycle.
- R10: Under mixed grant, return and consumer stall patterns, every granted byte is delivered exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of storage and credits |
| req_o | output | 1 | Fetch request to the upstream engine |
| gnt_i | input | 1 | Upstream grant of the current request |
| valid_i | input | 1 | Returned byte is present on data_i |
| data_i | input | 8 | Returned byte |
| ready_o | output | 1 | Space available for a returned byte |
| valid_o | output | 1 | A byte is available downstream |
| data_o | output | 8 | Oldest held byte |
| ready_i | input | 1 | Downstream consumer accepts data_o |

## Verification
The assertions assume the engine is well behaved. It returns a byte only for a request it has already granted, so valid_i never rises with a zero outstanding count. It also never returns into a full queue. Under that assumption the credit bound and the grant accounting hold on their own. The bench's upstream model raises valid_i only while its own list of granted but unreturned bytes is non-empty. On a clear it drops that list, and it holds valid_i, gnt_i and ready_i low during the clear cycle.

// File: rtl/cpf_pkg.sv
package cpf_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_PART  = 2'd1,
        FS_FULL  = 2'd2
    } fill_state_e;

endpackage

// File: rtl/cpf_fill_fsm.sv
module cpf_fill_fsm #(
    parameter int DEPTH = 2,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic             pop_i,
    output logic [LVL_W-1:0] level_o,
    output logic             full_o,
    output logic             empty_o
);
    import cpf_pkg::*;

    fill_state_e      state_q, state_d;
    logic [LVL_W-1:0] level_q, level_d;

    // occupancy counter
    always_comb begin
        level_d = level_q;
        if (push_i && !pop_i) begin
            level_d = level_q + LVL_W'(1);
        end else if (pop_i && !push_i) begin
            level_d = level_q - LVL_W'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            level_q <= '0;
        end else if (clr_i) begin
            level_q <= '0;
        end else begin
            level_q <= level_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = FS_EMPTY;
        end else begin
            unique case (state_q)
                FS_EMPTY: begin
                    if (push_i) state_d = (DEPTH == 1) ? FS_FULL : FS_PART;
                end
                FS_PART: begin
                    if (push_i && !pop_i && level_q == LVL_W'(DEPTH - 1)) begin
                        state_d = FS_FULL;
                    end else if (pop_i && !push_i && level_q == LVL_W'(1)) begin
                        state_d = FS_EMPTY;
                    end
                end
                FS_FULL: begin
                    if (pop_i && !push_i) state_d = (DEPTH == 1) ? FS_EMPTY : FS_PART;
                end
                default: state_d = FS_EMPTY;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FS_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs decoded from state
    always_comb begin
        full_o  = 1'b0;
        empty_o = 1'b0;
        unique case (state_q)
            FS_EMPTY: empty_o = 1'b1;
            FS_PART:  ;
            FS_FULL:  full_o  = 1'b1;
            default:  empty_o = 1'b1;
        endcase
    end

    assign level_o = level_q;

endmodule

// File: rtl/cpf_store.sv
module cpf_store #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] rdata_o
);
    logic [PTR_W-1:0] wptr_q, rptr_q;
    logic [WIDTH-1:0] mem_q [DEPTH];
    logic [DEPTH-1:0] slot_we;

    function automatic logic [PTR_W-1:0] ptr_step(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    for (genvar e = 0; e < DEPTH; e++) begin : g_slot
        assign slot_we[e] = push_i && (wptr_q == PTR_W'(e));
    end

    always_ff @(posedge clk_i) begin
        for (int e = 0; e < DEPTH; e++) begin
            if (slot_we[e]) mem_q[e] <= wdata_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else if (clr_i) begin
            wptr_q <= '0;
            rptr_q <= '0;
        end else begin
            if (push_i) wptr_q <= ptr_step(wptr_q);
            if (pop_i)  rptr_q <= ptr_step(rptr_q);
        end
    end

    assign rdata_o = mem_q[rptr_q];

endmodule

// File: rtl/cpf_credit.sv
module cpf_credit #(
    parameter int DEPTH = 2,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    input  logic             grant_i,
    input  logic             ret_i,
    output logic [CNT_W-1:0] outst_o
);
    logic [CNT_W-1:0] outst_q, outst_d;

    always_comb begin
        outst_d = outst_q;
        unique case ({grant_i, ret_i})
            2'b10:   outst_d = outst_q + CNT_W'(1);
            2'b01:   outst_d = outst_q - CNT_W'(1);
            default: outst_d = outst_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            outst_q <= '0;
        end else if (clr_i) begin
            outst_q <= '0;
        end else begin
            outst_q <= outst_d;
        end
    end

    assign outst_o = outst_q;

endmodule

// File: rtl/credit_prefetch_fifo.sv
module credit_prefetch_fifo #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clr_i,
    output logic             req_o,
    input  logic             gnt_i,
    input  logic             valid_i,
    input  logic [WIDTH-1:0] data_i,
    output logic             ready_o,
    output logic             valid_o,
    output logic [WIDTH-1:0] data_o,
    input  logic             ready_i
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int SUM_W = LVL_W + 1;

    logic             push, pop, grant, full, empty;
    logic [LVL_W-1:0] level, outst;
    logic [SUM_W-1:0] committed;

    assign ready_o   = !full;
    assign valid_o   = !empty;
    assign push      = valid_i && ready_o;
    assign pop       = valid_o && ready_i;
    assign committed = SUM_W'(level) + SUM_W'(outst);
    assign req_o     = !clr_i && !full && (committed < SUM_W'(DEPTH));
    assign grant     = req_o && gnt_i;

    cpf_fill_fsm #(.DEPTH(DEPTH)) fsm_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_i),
        .push_i  (push),
        .pop_i   (pop),
        .level_o (level),
        .full_o  (full),
        .empty_o (empty)
    );

    cpf_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) store_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_i),
        .push_i  (push),
        .pop_i   (pop),
        .wdata_i (data_i),
        .rdata_o (data_o)
    );

    cpf_credit #(.DEPTH(DEPTH)) credit_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clr_i   (clr_i),
        .grant_i (grant),
        .ret_i   (push),
        .outst_o (outst)
    );

endmodule

// File: rtl/cpf_checker.sv
module cpf_checker #(
    parameter int DEPTH = 2,
    parameter int WIDTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             clr_i,
    input logic             req_o,
    input logic             gnt_i,
    input logic             valid_i,
    input logic             ready_o,
    input logic             valid_o,
    input logic             ready_i,
    input logic [WIDTH-1:0] data_o,
    input logic [LVL_W-1:0] level_i,
    input logic [LVL_W-1:0] outst_i
);
    assert_credit_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (32'(level_i) + 32'(outst_i)) <= DEPTH);

    assert_no_req_when_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !ready_o |-> !req_o);

    assert_grant_counts_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_o && gnt_i && !(valid_i && ready_o)) |=> (outst_i == LVL_W'($past(outst_i) + 1'b1)));

    assert_valid_tracks_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_o == (level_i != '0));

    assert_hold_on_stall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_o && !ready_i && !clr_i) |=> (valid_o && $stable(data_o)));

    assert_clear_empties_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> (!valid_o && outst_i == '0));

endmodule

bind credit_prefetch_fifo cpf_checker #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (clr_i),
    .req_o   (req_o),
    .gnt_i   (gnt_i),
    .valid_i (valid_i),
    .ready_o (ready_o),
    .valid_o (valid_o),
    .ready_i (ready_i),
    .data_o  (data_o),
    .level_i (level),
    .outst_i (outst)
);

// File: tb/credit_prefetch_fifo_tb_top.sv
module credit_prefetch_fifo_tb_top;
    localparam int DEPTH = 2;
    localparam int WIDTH = 8;

    logic clk = 1'b0;
    logic rst_ni = 1'b0;
    logic clr_i = 1'b0, gnt_i = 1'b0, valid_i = 1'b0, ready_i = 1'b0;
    logic [WIDTH-1:0] data_i = '0;
    logic req_o, ready_o, valid_o;
    logic [WIDTH-1:0] data_o;

    always #2 clk = ~clk;

    credit_prefetch_fifo #(.DEPTH(DEPTH), .WIDTH(WIDTH)) dut_i (
        .clk_i(clk), .rst_ni(rst_ni), .clr_i(clr_i), .req_o(req_o), .gnt_i(gnt_i),
        .valid_i(valid_i), .data_i(data_i), .ready_o(ready_o), .valid_o(valid_o),
        .data_o(data_o), .ready_i(ready_i)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;
    bit run = 0;

    // stimulus modes: 0 off, 1 always, 2 pseudo-random
    int gnt_mode = 0, ret_mode = 0, rdy_mode = 0;
    bit clr_req = 0;

    logic [WIDTH-1:0] pending [$];   // granted, not yet returned
    logic [WIDTH-1:0] expq [$];      // scoreboard: expected output order
    int   m_level = 0, m_out = 0;
    int   byte_ctr = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit   hold_armed = 0;
    logic [WIDTH-1:0] hold_val = '0;
    bit   both_last = 0;
    logic pr_ready = 1'b0, pr_valid = 1'b0;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // driver and monitor, one cycle per negative edge
    always @(negedge clk) begin
        if (run) begin
            chk(ready_o == (m_level < DEPTH), "R2 ready_o", int'(ready_o), int'(m_level < DEPTH));
            chk(valid_o == (m_level != 0), "R6 valid_o", int'(valid_o), int'(m_level != 0));
            if (hold_armed)
                chk(valid_o && data_o == hold_val, "R7 hold", int'(data_o), int'(hold_val));
            if (both_last)
                chk(ready_o == pr_ready && valid_o == pr_valid, "R8 push+pop level",
                    int'({ready_o, valid_o}), int'({pr_ready, pr_valid}));

            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            clr_i = clr_req;
            if (clr_req) begin
                gnt_i = 1'b0; valid_i = 1'b0; ready_i = 1'b0;
            end else begin
                gnt_i   = (gnt_mode == 1) || (gnt_mode == 2 && lfsr[0]);
                valid_i = (pending.size() > 0) && ((ret_mode == 1) || (ret_mode == 2 && lfsr[1]));
                data_i  = (pending.size() > 0) ? pending[0] : 8'h00;
                ready_i = (rdy_mode == 1) || (rdy_mode == 2 && lfsr[2]);
            end
            #1;
            begin
                bit g, p, q;
                g = req_o && gnt_i;
                p = valid_i && ready_o;
                q = valid_o && ready_i;
                chk(req_o == (!clr_i && (m_level + m_out) < DEPTH),
                    clr_i ? "R9 req_o during clear" : "R3 req_o gating",
                    int'(req_o), int'(!clr_i && (m_level + m_out) < DEPTH));
                hold_armed = valid_o && !ready_i && !clr_i;
                hold_val   = data_o;
                both_last  = p && q && !clr_i;
                pr_ready   = ready_o;
                pr_valid   = valid_o;
                if (clr_i) begin
                    m_level = 0; m_out = 0;
                    pending.delete(); expq.delete();
                end else begin
                    if (q) begin
                        if (expq.size() > 0) begin
                            chk(data_o == expq[0], "R5 order/data", int'(data_o), int'(expq[0]));
                            void'(expq.pop_front());
                        end else begin
                            chk(1'b0, "R6 pop with nothing expected", 1, 0);
                        end
                    end
                    if (p) void'(pending.pop_front());
                    if (g) begin
                        logic [WIDTH-1:0] b;
                        b = WIDTH'(byte_ctr * 37 + 5);
                        byte_ctr++;
                        pending.push_back(b);
                        expq.push_back(b);
                    end
                    m_level = m_level + int'(p) - int'(q);
                    // R4: grant and return in one cycle cancel
                    if (g && !p) m_out++;
                    else if (p && !g) m_out--;
                end
            end
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_ni = 1'b1;
        @(negedge clk);
        #1;
        chk(valid_o == 1'b0, "R1 valid_o after reset", int'(valid_o), 0);
        chk(ready_o == 1'b1, "R1 ready_o after reset", int'(ready_o), 1);
        chk(req_o == 1'b1, "R1 req_o after reset", int'(req_o), 1);
        @(negedge clk);
        run = 1;
        // streaming: grant and return every cycle, consumer always ready
        gnt_mode = 1; ret_mode = 1; rdy_mode = 1;
        repeat (100) @(negedge clk);
        // consumer stalls: queue fills, requests stop (R3, R7)
        rdy_mode = 0;
        repeat (20) @(negedge clk);
        chk(req_o == 1'b0 && ready_o == 1'b0, "R3 full stops requests", int'({req_o, ready_o}), 0);
        // mixed patterns (R10)
        gnt_mode = 2; ret_mode = 2; rdy_mode = 2;
        repeat (400) @(negedge clk);
        // clear mid-stream (R9)
        clr_req = 1;
        @(negedge clk);
        clr_req = 0;
        #1;
        chk(valid_o == 1'b0, "R9 empty after clear", int'(valid_o), 0);
        chk(ready_o == 1'b1, "R9 ready after clear", int'(ready_o), 1);
        gnt_mode = 2; ret_mode = 2; rdy_mode = 2;
        repeat (400) @(negedge clk);
        // drain
        gnt_mode = 0; ret_mode = 1; rdy_mode = 1;
        repeat (30) @(negedge clk);
        #1;
        chk(expq.size() == 0 && pending.size() == 0, "R10 all bytes delivered",
            expq.size() + pending.size(), 0);
        chk(byte_ctr > 100, "R10 enough traffic", byte_ctr, 101);
        run = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule